// File: doc/BRIEF.md
# Two-Tier Packet Buffer Allocator

This block hands out and takes back the indices of fixed-size packet buffers. Each buffer index stands for one 1536-byte block of packet memory. There are 16 input ports. Every port owns a private group of eight buffers, tracked as a bitmap. Together these groups are the buffers numbered 0 to 127. All higher-numbered buffers form a shared pool. The shared pool is kept as linked lists in two banks, and the next-pointer table is held internally.

A port raises its request line when it is activated, which gives it its first buffer. It raises the line again each time an arriving frame takes up the buffer it holds. The grant appears in the same cycle as the request, with the buffer index beside it. The port must then drop its request. Once a buffer has been transmitted successfully, it comes back through the release input. A synchronous initialisation input puts every pool back into its starting state.

Top module: `pkt_buf_alloc`

## Requirements
- R1: After reset, all 128 private buffers are free, `shared_free` reads 128, no grant is shown and `exhausted` is low.
- R2: A granted port that still has a free private buffer receives the lowest-numbered free bit `b` of its group. The index is `port*8 + b`.
- R3: A port receives a shared buffer (index 128 or above) only when its private group holds no free buffer.
- R4: The bank of a shared index is its bit 0 (even means bank 0, odd means bank 1). The first shared grant after initialisation comes from bank 0. While both banks hold buffers, shared grants alternate between banks. When only one bank holds buffers, grants come from that bank.
- R5: After initialisation, bank 0 hands out 128, 130, 132 and so on in ascending order, and bank 1 hands out 129, 131 and so on. A released shared index goes to the front of its bank's list, so it is the next buffer that bank hands out.
- R6: Releasing an index below 128 makes that buffer free again in the group of port `index/8`.
- R7: At most one grant is given per cycle, and only to a requesting port. The search begins at the port after the most recently granted one, wrapping from port 15 to port 0.
- R8: A request from a port whose private group is empty, made while the shared pool is also empty, gets no grant and raises `exhausted` in that cycle. Other ports can still be granted.
- R9: `shared_free` equals the number of free shared buffers. It updates on the clock edge after a shared grant or a shared release.
- R10: A one-cycle `init` pulse restores the state described in R1, including the order in R5 and the round-robin start at port 0.
- R11: A grant and a release in the same cycle both take effect, even when they touch the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| init | input | 1 | Synchronous initialisation pulse |
| alloc_req | input | 16 | Per-port allocation request, held until granted |
| alloc_gnt | output | 16 | One-hot grant, valid in the request cycle |
| alloc_idx | output | 8 | Buffer index for the granted port |
| rel_vld | input | 1 | Release strobe |
| rel_idx | input | 8 | Index of the buffer being released |
| shared_free | output | 8 | Count of free shared buffers |
| exhausted | output | 1 | A request is blocked because both pools are empty |

## Verification
The assertions assume that every index released is currently held, so no buffer is freed twice or freed without having been granted. They also assume that a port drops its request in the cycle after it is granted. The stimulus meets both conditions. It releases only indices that the reference model shows as allocated. It changes the request vector only between cycles, and it holds a request for exactly one cycle. That one cycle is enough because the grant is combinational.

// File: rtl/pkt_buf_alloc.sv
module pkt_buf_alloc #(
  parameter int NPORTS = 16,
  parameter int GRP = 8,
  parameter int NODES = 256,
  localparam int PRIV = NPORTS * GRP,
  localparam int SH = NODES - PRIV,
  localparam int IW = $clog2(NODES),
  localparam int PW = $clog2(NPORTS),
  localparam int GW = $clog2(GRP),
  localparam int CW = $clog2(SH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [NPORTS-1:0] alloc_req,
  output logic [NPORTS-1:0] alloc_gnt,
  output logic [IW-1:0]     alloc_idx,
  input  logic              rel_vld,
  input  logic [IW-1:0]     rel_idx,
  output logic [CW-1:0]     shared_free,
  output logic              exhausted
);

  logic [NPORTS-1:0][GRP-1:0] pmap;
  logic [IW-1:0] head [2];
  logic [CW-1:0] cnt [2];
  logic [IW-1:0] nxt [NODES];
  logic [PW-1:0] rr, win;
  logic [GW-1:0] pbit;
  logic [NPORTS-1:0] priv_any, elig;
  logic win_vld, last_b, sel_b, sh_avail, use_priv;
  logic [1:0] pop, push;

  always_comb
    for (int p = 0; p < NPORTS; p++) priv_any[p] = |pmap[p];

  assign sh_avail = (cnt[0] != '0) || (cnt[1] != '0);
  assign elig = alloc_req & (priv_any | {NPORTS{sh_avail}});
  assign exhausted = !sh_avail && |(alloc_req & ~priv_any);
  assign shared_free = cnt[0] + cnt[1];

  always_comb begin
    win = '0;
    win_vld = 1'b0;
    for (int k = 0; k < NPORTS; k++)
      if (!win_vld && elig[(int'(rr) + k) % NPORTS]) begin
        win_vld = 1'b1;
        win = PW'((int'(rr) + k) % NPORTS);
      end
  end

  always_comb begin
    pbit = '0;
    for (int b = GRP - 1; b >= 0; b--)
      if (pmap[win][b]) pbit = GW'(b);
  end

  assign use_priv = priv_any[win];
  assign sel_b = (cnt[0] != '0 && cnt[1] != '0) ? ~last_b : (cnt[1] != '0);

  assign alloc_gnt = win_vld ? (NPORTS'(1) << win) : '0;
  assign alloc_idx = !win_vld ? '0 : use_priv ? IW'({win, pbit}) : head[sel_b];

  always_comb
    for (int b = 0; b < 2; b++) begin
      pop[b]  = win_vld && !use_priv && (sel_b == b[0]);
      push[b] = rel_vld && (int'(rel_idx) >= PRIV) && (rel_idx[0] == b[0]);
    end

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      for (int p = 0; p < NPORTS; p++) pmap[p] <= '1;
      for (int i = PRIV; i < NODES; i++) nxt[i] <= IW'(i + 2);
      head[0] <= IW'(PRIV);
      head[1] <= IW'(PRIV + 1);
      cnt[0] <= CW'(SH / 2);
      cnt[1] <= CW'(SH / 2);
      rr <= '0;
      last_b <= 1'b1;
    end else begin
      if (win_vld) begin
        rr <= PW'((int'(win) + 1) % NPORTS);
        if (use_priv) pmap[win][pbit] <= 1'b0;
        else last_b <= sel_b;
      end
      if (rel_vld && int'(rel_idx) < PRIV)
        pmap[rel_idx[GW+:PW]][rel_idx[GW-1:0]] <= 1'b1;
      for (int b = 0; b < 2; b++) begin
        if (push[b]) begin
          head[b] <= rel_idx;
          nxt[rel_idx] <= pop[b] ? nxt[head[b]] : head[b];
        end else if (pop[b]) begin
          head[b] <= nxt[head[b]];
        end
        cnt[b] <= cnt[b] + CW'(push[b]) - CW'(pop[b]);
      end
    end
  end

endmodule

// File: rtl/pkt_buf_alloc_chk.sv
module pkt_buf_alloc_chk #(
  parameter int NPORTS = 16,
  parameter int GRP = 8,
  parameter int NODES = 256,
  localparam int PRIV = NPORTS * GRP,
  localparam int SH = NODES - PRIV,
  localparam int IW = $clog2(NODES),
  localparam int PW = $clog2(NPORTS),
  localparam int GW = $clog2(GRP),
  localparam int CW = $clog2(SH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic [NPORTS-1:0] alloc_req,
  input logic [NPORTS-1:0] alloc_gnt,
  input logic [IW-1:0]     alloc_idx,
  input logic              rel_vld,
  input logic [IW-1:0]     rel_idx,
  input logic [CW-1:0]     shared_free,
  input logic              exhausted
);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(alloc_gnt)); // R7
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (alloc_gnt & ~alloc_req) == '0); // R7
  AST_PRIV_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_gnt && int'(alloc_idx) < PRIV) |-> alloc_gnt[alloc_idx[GW+:PW]]); // R2
  AST_SHARED_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_gnt && int'(alloc_idx) >= PRIV) |-> shared_free != '0); // R3
  AST_EXHAUST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) exhausted |-> shared_free == '0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(shared_free) <= SH); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_gnt && int'(alloc_idx) >= PRIV && !rel_vld && !init)
    |=> int'(shared_free) == int'($past(shared_free)) - 1); // R9
  AST_INIT_FULL: assert property (@(posedge clk) disable iff (!rst_n) init |=> int'(shared_free) == SH); // R10

endmodule

bind pkt_buf_alloc pkt_buf_alloc_chk #(.NPORTS(NPORTS), .GRP(GRP), .NODES(NODES)) chk_i (
  .clk(clk), .rst_n(rst_n), .init(init), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
  .alloc_idx(alloc_idx), .rel_vld(rel_vld), .rel_idx(rel_idx), .shared_free(shared_free),
  .exhausted(exhausted)
);

// File: tb/pkt_buf_alloc_tb_top.sv
module pkt_buf_alloc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0;
  logic [15:0] req = '0;
  logic rel_vld = 1'b0;
  logic [7:0] rel_idx = '0;
  logic [15:0] gnt;
  logic [7:0] idx;
  logic [7:0] sfree;
  logic exh;

  pkt_buf_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .alloc_req(req), .alloc_gnt(gnt),
    .alloc_idx(idx), .rel_vld(rel_vld), .rel_idx(rel_idx), .shared_free(sfree),
    .exhausted(exh)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit pm [16][8];
  int q0[$], q1[$];
  int rr, lastb;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit pany(int p);
    for (int b = 0; b < 8; b++) if (pm[p][b]) return 1;
    return 0;
  endfunction

  task automatic model_init();
    for (int p = 0; p < 16; p++) for (int b = 0; b < 8; b++) pm[p][b] = 1;
    q0.delete(); q1.delete();
    for (int i = 128; i < 256; i += 2) begin q0.push_back(i); q1.push_back(i + 1); end
    rr = 0; lastb = 1;
  endtask

  task automatic step(string tag, logic [15:0] r, bit fv, int fi);
    int win, expidx, expexh, bank, shn;
    req = r; rel_vld = fv; rel_idx = fi[7:0];
    #1;
    shn = q0.size() + q1.size();
    win = -1;
    for (int k = 0; k < 16; k++) begin
      int p = (rr + k) % 16;
      if (win < 0 && r[p] && (pany(p) || shn > 0)) win = p;
    end
    expexh = 0;
    for (int p = 0; p < 16; p++) if (r[p] && !pany(p) && shn == 0) expexh = 1;
    chk(tag, "R9 shared_free", int'(sfree), shn);
    chk(tag, "R8 exhausted", int'(exh), expexh);
    expidx = 0;
    if (win >= 0) begin
      if (pany(win)) begin
        for (int b = 7; b >= 0; b--) if (pm[win][b]) expidx = win * 8 + b;
        pm[win][expidx % 8] = 0;
      end else begin
        bank = (q0.size() > 0 && q1.size() > 0) ? 1 - lastb : (q1.size() > 0);
        expidx = (bank == 1) ? q1.pop_front() : q0.pop_front();
        lastb = bank;
      end
      rr = (win + 1) % 16;
    end
    chk(tag, "R7 grant", int'(gnt), (win >= 0) ? (1 << win) : 0);
    chk(tag, "index", int'(idx), expidx);
    if (fv) begin
      if (fi < 128) pm[fi / 8][fi % 8] = 1;
      else if (fi % 2 == 1) q1.push_front(fi);
      else q0.push_front(fi);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_init();
    req = '0; rel_vld = 0; init = 1;
    @(posedge clk);
    @(negedge clk);
    init = 0;
    model_init();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_init();
    step("R1", 16'h0000, 0, 0);
    step("R1", 16'h0000, 0, 0);
    repeat (3) step("R2", 16'h0008, 0, 0);
    repeat (20) step("R7", 16'hFFFF, 0, 0);
    step("R6", 16'h0000, 1, 25);
    step("R6", 16'h0008, 0, 0);
    repeat (8) step("R3", 16'h0001, 0, 0);
    repeat (4) step("R4", 16'h0001, 0, 0);
    step("R5", 16'h0000, 1, 128);
    step("R5", 16'h0001, 0, 0);
    step("R5", 16'h0001, 0, 0);
    step("R11", 16'h0001, 1, 131);
    step("R11", 16'h0001, 0, 0);
    step("R9", 16'h0000, 1, 129);
    repeat (130) step("R8", 16'h0001, 0, 0);
    step("R8", 16'h0021, 0, 0);
    step("R8", 16'h0001, 1, 200);
    step("R8", 16'h0001, 0, 0);
    step("R4", 16'h0000, 1, 201);
    step("R4", 16'h0000, 1, 203);
    repeat (2) step("R4", 16'h0001, 0, 0);
    do_init();
    step("R10", 16'h0000, 0, 0);
    step("R10", 16'h0001, 0, 0);
    step("R10", 16'h8000, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule